// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits between a host register bus and the wide storage behind it. The host bus carries one write per cycle, either 32 or 64 bits wide. The storage behind the block is a bank of 128-bit control registers and an SRAM of 64-bit words. A single collector gathers the partial writes. The collector holds a target key, a 4-bit dword-valid mask and 128 bits of data. A register is written only when all four of its dwords have arrived. An SRAM word is written only when both of its dwords have arrived. Each commit is a single-cycle strobe that carries the full value and its index. There is no back-pressure toward the host.

The paged region holds per-interface pages with a stride of 0x2000 bytes. Each page contains two write-only descriptor-pointer registers, one for receive at page offset 0x830 and one for transmit at page offset 0xa10. A write that reaches the top dword of a descriptor pointer always commits that pointer. Any low dword not held by the collector for that pointer is filled with zero, so the host needs no locking for these registers. Each page also has two plain 32-bit registers, at page offsets 0x400 and 0x420. These are forwarded directly without collection. A write to offset 0x420 of page 0 also empties the collector.

Top module: `wide_wr_collector`

## Requirements
- R1: After reset all four write strobes are low and the collector is empty. Data collected before a reset therefore never reaches a later commit.
- R2: Host address bits [AW-1:AW-2] = 2'b10 select the 128-bit register bank, and the register index is address bits [AW-3:4]. Address bits [3:2] select the dword, and dword k occupies data bits [32k+31:32k]. A 64-bit write fills dwords 0-1 when address bit 3 is 0 and dwords 2-3 when it is 1. The 128-bit register is written once all four dwords are valid for the same index, whatever order they arrive in.
- R3: A 64-bit write with address bit 2 set is misaligned. It is ignored and produces no strobe.
- R4: A partial write to a register index other than the one held in the collector restarts collection for the new index. A later complete set of dwords commits only the new register, with only the new data.
- R5: Address bits [AW-1:AW-2] = 2'b11 select the SRAM, and the word index is address bits [AW-3:3]. A word is written as {high dword, low dword} once both of its dwords are valid. A dword for a different word restarts collection.
- R6: When address bit AW-1 is 0, the paged region is selected. The page number is address bits [AW-2:13] and the page offset is bits [12:0]. A write covering the top dword of a descriptor pointer always commits it, receive at offset 0x830 (desc_wr_tx = 0) and transmit at offset 0xa10 (desc_wr_tx = 1). Low dwords not collected for that same pointer are written as zero.
- R7: A write to a lower dword of a descriptor pointer is discarded while the collector holds data for a different target, and the collector is left unchanged.
- R8: A 32-bit write to page offset 0x400 (dw_wr_sel = 0) or 0x420 (dw_wr_sel = 1) is forwarded with its page and data, without collection. A 64-bit write to these offsets is ignored.
- R9: A 32-bit write to offset 0x420 in page 0 empties the collector. The same write in any other page leaves the collector intact.
- R10: Every strobe appears in the cycle after the host write that causes it and lasts exactly one cycle. At most one strobe is active per cycle.
- R11: A top-dword descriptor commit leaves the collector unchanged when the collector holds data for a different target.
- R12: Writes to any other offset of the paged region are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host write valid, one write per cycle |
| host_wr_qword | input | 1 | 1 = 64-bit write, 0 = 32-bit write |
| host_addr | input | AW | Host byte address |
| host_wdata | input | 64 | Write data; a 32-bit write uses bits [31:0] |
| csr_wr_en | output | 1 | 128-bit register write strobe |
| csr_wr_idx | output | AW-6 | 128-bit register index |
| wide_wr_data | output | 128 | Value for a register or descriptor-pointer commit |
| desc_wr_en | output | 1 | Descriptor-pointer write strobe |
| desc_wr_tx | output | 1 | 0 = receive pointer, 1 = transmit pointer |
| page_idx | output | AW-14 | Page of a descriptor or direct write |
| sram_wr_en | output | 1 | SRAM word write strobe |
| sram_wr_idx | output | AW-5 | SRAM word index |
| sram_wr_data | output | 64 | SRAM word value |
| dw_wr_en | output | 1 | Direct 32-bit register write strobe |
| dw_wr_sel | output | 1 | 0 = offset 0x400, 1 = offset 0x420 |
| dw_wr_data | output | 32 | Direct register value |

## Verification
Every result of this block falls due exactly one clock edge after the host write that causes it. That holds for a register commit, an SRAM commit, a descriptor commit and a direct forward alike. The bench drives each write on a falling edge and holds it for one cycle. It then samples all strobes and data on the next falling edge, which sits in the middle of the cycle in which the registered outputs are valid. The bench checks both the writes that commit and the writes that must not. For a write that is ignored or discarded, the bench checks in that same sampling slot that no strobe fired. It then shows any effect on the collector through the data of a later commit.

// File: rtl/wwc_pkg.sv
package wwc_pkg;
  typedef enum logic [2:0] {
    K_NONE,
    K_CSR,
    K_SRAM,
    K_DESC,
    K_DIRECT
  } kind_e;

  localparam logic [31:0] OFF_RX_PTR = 32'h830;
  localparam logic [31:0] OFF_TX_PTR = 32'ha10;
  localparam logic [31:0] OFF_PLAIN0 = 32'h400;
  localparam logic [31:0] OFF_PLAIN1 = 32'h420;

  localparam logic [1:0] REG_CSR  = 2'b10;
  localparam logic [1:0] REG_SRAM = 2'b11;
endpackage

// File: rtl/wwc_decode.sv
module wwc_decode
  import wwc_pkg::*;
#(
  parameter int AW = 20,
  parameter int PAGE_SHIFT = 13
) (
  input  logic          wr_en,
  input  logic          wr_qword,
  input  logic [AW-1:0] addr,
  input  logic [63:0]   wdata,
  output kind_e         kind,
  output logic [3:0]    wmask,
  output logic [127:0]  lanes,
  output logic          tx_sel,
  output logic          plain_sel,
  output logic          inval
);
  localparam int PG_W = AW - 1 - PAGE_SHIFT;

  logic [PAGE_SHIFT-1:0] off;
  logic [PG_W-1:0]       page;
  logic                  hit_rx;
  logic                  hit_tx;
  logic                  hit_p0;
  logic                  hit_p1;

  assign off    = addr[PAGE_SHIFT-1:0];
  assign page   = addr[AW-2:PAGE_SHIFT];
  assign hit_rx = (32'(off) >> 4) == (OFF_RX_PTR >> 4);
  assign hit_tx = (32'(off) >> 4) == (OFF_TX_PTR >> 4);
  assign hit_p0 = (32'(off) >> 2) == (OFF_PLAIN0 >> 2);
  assign hit_p1 = (32'(off) >> 2) == (OFF_PLAIN1 >> 2);

  assign wmask = wr_qword ? (addr[3] ? 4'b1100 : 4'b0011)
                          : (4'b0001 << addr[3:2]);
  assign lanes = wr_qword ? {2{wdata}} : {4{wdata[31:0]}};
  assign tx_sel    = hit_tx;
  assign plain_sel = hit_p1;

  always_comb begin
    kind  = K_NONE;
    inval = 1'b0;
    if (wr_en && !(wr_qword && addr[2])) begin
      if (addr[AW-1:AW-2] == REG_CSR) begin
        kind = K_CSR;
      end else if (addr[AW-1:AW-2] == REG_SRAM) begin
        kind = K_SRAM;
      end else if (!addr[AW-1]) begin
        if (hit_rx || hit_tx) begin
          kind = K_DESC;
        end else if (!wr_qword && (hit_p0 || hit_p1)) begin
          kind  = K_DIRECT;
          inval = hit_p1 && (page == '0);
        end
      end
    end
  end
endmodule

// File: rtl/wwc_collector.sv
module wwc_collector
  import wwc_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  kind_e         kind,
  input  logic [3:0]    wmask,
  input  logic [127:0]  lanes,
  input  logic [AW-1:3] key,
  output logic          cm_csr,
  output logic          cm_sram,
  output logic          cm_desc,
  output logic [127:0]  cm_data
);
  localparam int LANES = 4;

  logic [AW-1:3]  c_key,  c_key_n;
  logic [3:0]     c_mask, c_mask_n;
  logic [127:0]   c_data, c_data_n;

  logic           held;
  logic           match_reg;
  logic           match_word;
  logic [3:0]     new_mask;
  logic [127:0]   m_data;
  logic [127:0]   z_data;
  logic [1:0]     half_mask;

  assign held       = (c_mask != '0);
  assign match_reg  = held && (c_key[AW-1:4] == key[AW-1:4]);
  assign match_word = held && (c_key == key);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign m_data[32*i +: 32] = wmask[i] ? lanes[32*i +: 32] : c_data[32*i +: 32];
    assign z_data[32*i +: 32] = wmask[i] ? lanes[32*i +: 32] :
                                (match_reg && c_mask[i]) ? c_data[32*i +: 32] : 32'h0;
  end

  always_comb begin
    new_mask  = wmask | (((kind == K_SRAM) ? match_word : match_reg) ? c_mask : 4'b0000);
    half_mask = key[3] ? new_mask[3:2] : new_mask[1:0];
  end

  always_comb begin
    c_key_n  = c_key;
    c_mask_n = c_mask;
    c_data_n = c_data;
    cm_csr   = 1'b0;
    cm_sram  = 1'b0;
    cm_desc  = 1'b0;
    cm_data  = m_data;
    unique case (kind)
      K_CSR: begin
        if (new_mask == 4'hF) begin
          cm_csr   = 1'b1;
          c_mask_n = '0;
        end else begin
          c_key_n  = key;
          c_mask_n = new_mask;
          c_data_n = m_data;
        end
      end
      K_SRAM: begin
        if (half_mask == 2'b11) begin
          cm_sram  = 1'b1;
          cm_data  = {64'h0, key[3] ? m_data[127:64] : m_data[63:0]};
          c_mask_n = '0;
        end else begin
          c_key_n  = key;
          c_mask_n = new_mask;
          c_data_n = m_data;
        end
      end
      K_DESC: begin
        if (wmask[3]) begin
          cm_desc = 1'b1;
          cm_data = z_data;
          if (match_reg) c_mask_n = '0;
        end else if (!held || match_reg) begin
          c_key_n  = key;
          c_mask_n = new_mask;
          c_data_n = m_data;
        end
      end
      K_DIRECT: begin
        c_mask_n = '0;
      end
      default: begin
      end
    endcase
  end

  logic inval_en;
  assign inval_en = (kind != K_DIRECT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_key  <= '0;
      c_mask <= '0;
      c_data <= '0;
    end else begin
      c_key  <= c_key_n;
      c_data <= c_data_n;
      if (inval_en || (c_mask_n == '0)) c_mask <= c_mask_n;
    end
  end
endmodule

// File: rtl/wwc_outreg.sv
module wwc_outreg
  import wwc_pkg::*;
#(
  parameter int AW = 20,
  parameter int PAGE_SHIFT = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cm_csr,
  input  logic                    cm_sram,
  input  logic                    cm_desc,
  input  logic                    cm_direct,
  input  logic [127:0]            cm_data,
  input  logic [AW-1:0]           addr,
  input  logic [31:0]             dword,
  input  logic                    tx_sel,
  input  logic                    plain_sel,
  output logic                    csr_wr_en,
  output logic [AW-7:0]           csr_wr_idx,
  output logic [127:0]            wide_wr_data,
  output logic                    desc_wr_en,
  output logic                    desc_wr_tx,
  output logic [AW-2-PAGE_SHIFT:0] page_idx,
  output logic                    sram_wr_en,
  output logic [AW-6:0]           sram_wr_idx,
  output logic [63:0]             sram_wr_data,
  output logic                    dw_wr_en,
  output logic                    dw_wr_sel,
  output logic [31:0]             dw_wr_data
);
  logic wide_ce;
  logic page_ce;

  assign wide_ce = cm_csr || cm_desc;
  assign page_ce = cm_desc || cm_direct;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_wr_en  <= 1'b0;
      desc_wr_en <= 1'b0;
      sram_wr_en <= 1'b0;
      dw_wr_en   <= 1'b0;
    end else begin
      csr_wr_en  <= cm_csr;
      desc_wr_en <= cm_desc;
      sram_wr_en <= cm_sram;
      dw_wr_en   <= cm_direct;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_wr_idx   <= '0;
      wide_wr_data <= '0;
      desc_wr_tx   <= 1'b0;
      page_idx     <= '0;
      sram_wr_idx  <= '0;
      sram_wr_data <= '0;
      dw_wr_sel    <= 1'b0;
      dw_wr_data   <= '0;
    end else begin
      if (wide_ce) wide_wr_data <= cm_data;
      if (cm_csr)  csr_wr_idx   <= addr[AW-3:4];
      if (cm_desc) desc_wr_tx   <= tx_sel;
      if (page_ce) page_idx     <= addr[AW-2:PAGE_SHIFT];
      if (cm_sram) begin
        sram_wr_idx  <= addr[AW-3:3];
        sram_wr_data <= cm_data[63:0];
      end
      if (cm_direct) begin
        dw_wr_sel  <= plain_sel;
        dw_wr_data <= dword;
      end
    end
  end
endmodule

// File: rtl/wide_wr_collector.sv
module wide_wr_collector
  import wwc_pkg::*;
#(
  parameter int AW = 20,
  parameter int PAGE_SHIFT = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     host_wr_en,
  input  logic                     host_wr_qword,
  input  logic [AW-1:0]            host_addr,
  input  logic [63:0]              host_wdata,
  output logic                     csr_wr_en,
  output logic [AW-7:0]            csr_wr_idx,
  output logic [127:0]             wide_wr_data,
  output logic                     desc_wr_en,
  output logic                     desc_wr_tx,
  output logic [AW-2-PAGE_SHIFT:0] page_idx,
  output logic                     sram_wr_en,
  output logic [AW-6:0]            sram_wr_idx,
  output logic [63:0]              sram_wr_data,
  output logic                     dw_wr_en,
  output logic                     dw_wr_sel,
  output logic [31:0]              dw_wr_data
);
  kind_e        kind;
  logic [3:0]   wmask;
  logic [127:0] lanes;
  logic         tx_sel;
  logic         plain_sel;
  logic         inval;
  logic         cm_csr;
  logic         cm_sram;
  logic         cm_desc;
  logic [127:0] cm_data;
  kind_e        kind_c;

  wwc_decode #(.AW(AW), .PAGE_SHIFT(PAGE_SHIFT)) u_dec (
    .wr_en     (host_wr_en),
    .wr_qword  (host_wr_qword),
    .addr      (host_addr),
    .wdata     (host_wdata),
    .kind      (kind),
    .wmask     (wmask),
    .lanes     (lanes),
    .tx_sel    (tx_sel),
    .plain_sel (plain_sel),
    .inval     (inval)
  );

  assign kind_c = (kind == K_DIRECT && !inval) ? K_NONE : kind;

  wwc_collector #(.AW(AW)) u_col (
    .clk     (clk),
    .rst_n   (rst_n),
    .kind    (kind_c),
    .wmask   (wmask),
    .lanes   (lanes),
    .key     (host_addr[AW-1:3]),
    .cm_csr  (cm_csr),
    .cm_sram (cm_sram),
    .cm_desc (cm_desc),
    .cm_data (cm_data)
  );

  wwc_outreg #(.AW(AW), .PAGE_SHIFT(PAGE_SHIFT)) u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .cm_csr       (cm_csr),
    .cm_sram      (cm_sram),
    .cm_desc      (cm_desc),
    .cm_direct    (kind == K_DIRECT),
    .cm_data      (cm_data),
    .addr         (host_addr),
    .dword        (host_wdata[31:0]),
    .tx_sel       (tx_sel),
    .plain_sel    (plain_sel),
    .csr_wr_en    (csr_wr_en),
    .csr_wr_idx   (csr_wr_idx),
    .wide_wr_data (wide_wr_data),
    .desc_wr_en   (desc_wr_en),
    .desc_wr_tx   (desc_wr_tx),
    .page_idx     (page_idx),
    .sram_wr_en   (sram_wr_en),
    .sram_wr_idx  (sram_wr_idx),
    .sram_wr_data (sram_wr_data),
    .dw_wr_en     (dw_wr_en),
    .dw_wr_sel    (dw_wr_sel),
    .dw_wr_data   (dw_wr_data)
  );
endmodule

// File: rtl/wwc_checker.sv
module wwc_checker #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_wr_en,
  input logic          host_wr_qword,
  input logic [AW-1:0] host_addr,
  input logic          csr_wr_en,
  input logic          desc_wr_en,
  input logic          sram_wr_en,
  input logic          dw_wr_en
);
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({csr_wr_en, desc_wr_en, sram_wr_en, dw_wr_en})); // R10

  AST_CSR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wr_en |=> !csr_wr_en); // R10

  AST_CSR_FROM_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wr_en |-> $past(host_wr_en && host_addr[AW-1:AW-2] == 2'b10)); // R2

  AST_MISALIGNED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_en && host_wr_qword && host_addr[2])
      |=> !(csr_wr_en || desc_wr_en || sram_wr_en || dw_wr_en)); // R3

  AST_SRAM_FROM_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    sram_wr_en |-> $past(host_wr_en && host_addr[AW-1:AW-2] == 2'b11)); // R5

  AST_DESC_NEEDS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr_en |-> $past(host_wr_en && host_addr[3] && !host_addr[AW-1])); // R6

  AST_DIRECT_IS_DWORD: assert property (@(posedge clk) disable iff (!rst_n)
    dw_wr_en |-> $past(host_wr_en && !host_wr_qword && !host_addr[AW-1])); // R8
endmodule

bind wide_wr_collector wwc_checker #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .host_wr_en    (host_wr_en),
  .host_wr_qword (host_wr_qword),
  .host_addr     (host_addr),
  .csr_wr_en     (csr_wr_en),
  .desc_wr_en    (desc_wr_en),
  .sram_wr_en    (sram_wr_en),
  .dw_wr_en      (dw_wr_en)
);

// File: tb/wide_wr_collector_tb.sv
`timescale 1ns/1ps
module wide_wr_collector_tb;
  localparam int AW = 20;
  localparam int PS = 13;

  logic           clk;
  logic           rst_n;
  logic           host_wr_en;
  logic           host_wr_qword;
  logic [AW-1:0]  host_addr;
  logic [63:0]    host_wdata;
  logic           csr_wr_en;
  logic [AW-7:0]  csr_wr_idx;
  logic [127:0]   wide_wr_data;
  logic           desc_wr_en;
  logic           desc_wr_tx;
  logic [AW-2-PS:0] page_idx;
  logic           sram_wr_en;
  logic [AW-6:0]  sram_wr_idx;
  logic [63:0]    sram_wr_data;
  logic           dw_wr_en;
  logic           dw_wr_sel;
  logic [31:0]    dw_wr_data;

  int n_checks;
  int n_fail;

  wide_wr_collector #(.AW(AW), .PAGE_SHIFT(PS)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_wr_qword(host_wr_qword),
    .host_addr(host_addr), .host_wdata(host_wdata), .csr_wr_en(csr_wr_en),
    .csr_wr_idx(csr_wr_idx), .wide_wr_data(wide_wr_data), .desc_wr_en(desc_wr_en),
    .desc_wr_tx(desc_wr_tx), .page_idx(page_idx), .sram_wr_en(sram_wr_en),
    .sram_wr_idx(sram_wr_idx), .sram_wr_data(sram_wr_data), .dw_wr_en(dw_wr_en),
    .dw_wr_sel(dw_wr_sel), .dw_wr_data(dw_wr_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic        qw;
    logic [19:0] a;
    logic [63:0] d;
    logic [3:0]  st;   // {csr, desc, sram, dw}
    logic [31:0] sig;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 20'h80010, 64'h11,                 4'b0000, 32'h0},
    '{1'b0, 20'h80014, 64'h22,                 4'b0000, 32'h0},
    '{1'b1, 20'h80018, 64'h00000044_00000033,  4'b1000, 32'h44},
    '{1'b1, 20'hC0008, 64'h00000005_00000006,  4'b0010, 32'h3},
    '{1'b0, 20'hC0010, 64'hA,                  4'b0000, 32'h0},
    '{1'b0, 20'hC0014, 64'hB,                  4'b0010, 32'h1},
    '{1'b0, 20'h02400, 64'h77,                 4'b0001, 32'h77},
    '{1'b0, 20'h0483C, 64'h99,                 4'b0100, 32'h99},
    '{1'b1, 20'h80004, 64'hFFFF,               4'b0000, 32'h0},
    '{1'b0, 20'h02100, 64'h55,                 4'b0000, 32'h0}
  };

  function automatic logic [3:0] strobes();
    return {csr_wr_en, desc_wr_en, sram_wr_en, dw_wr_en};
  endfunction

  function automatic logic [31:0] signature();
    if (csr_wr_en || desc_wr_en)
      return wide_wr_data[31:0] ^ wide_wr_data[63:32] ^ wide_wr_data[95:64] ^ wide_wr_data[127:96];
    if (sram_wr_en) return sram_wr_data[31:0] ^ sram_wr_data[63:32];
    if (dw_wr_en)   return dw_wr_data;
    return 32'h0;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive on a falling edge; outputs are sampled on the next falling edge
  task automatic wr(input logic qw, input logic [AW-1:0] a, input logic [63:0] d);
    @(negedge clk);
    host_wr_en    = 1'b1;
    host_wr_qword = qw;
    host_addr     = a;
    host_wdata    = d;
    @(negedge clk);
    host_wr_en    = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    n_checks = 0;
    n_fail = 0;
    host_wr_en = 1'b0;
    host_wr_qword = 1'b0;
    host_addr = '0;
    host_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 strobes idle after reset", 128'(strobes()), 128'h0);

    // table walk: R2 R3 R5 R6 R8 R12
    for (int i = 0; i < NV; i++) begin
      wr(TBL[i].qw, TBL[i].a, TBL[i].d);
      check($sformatf("R2/R3/R5/R6/R8/R12 vector %0d strobes", i), 128'(strobes()), 128'(TBL[i].st));
      check($sformatf("R2/R3/R5/R6/R8/R12 vector %0d data", i), 128'(signature()), 128'(TBL[i].sig));
    end

    // R2 full value and index, out-of-order dwords; R10 one-cycle strobe
    wr(1'b0, 20'h8003C, 64'hD3);
    wr(1'b0, 20'h80030, 64'hD0);
    wr(1'b0, 20'h80038, 64'hD2);
    wr(1'b0, 20'h80034, 64'hD1);
    check("R2 commit strobe", 128'(csr_wr_en), 128'h1);
    check("R2 commit index", 128'(csr_wr_idx), 128'h3);
    check("R2 commit value", wide_wr_data, {32'hD3, 32'hD2, 32'hD1, 32'hD0});
    @(negedge clk);
    check("R10 strobe lasts one cycle", 128'(strobes()), 128'h0);

    // R4 restart on a different index
    wr(1'b0, 20'h80050, 64'hE0);
    wr(1'b0, 20'h80054, 64'hE1);
    wr(1'b0, 20'h80060, 64'hF0);
    wr(1'b1, 20'h80068, 64'h000000F3_000000F2);
    check("R4 no commit before new set complete", 128'(csr_wr_en), 128'h0);
    wr(1'b0, 20'h80064, 64'hF1);
    check("R4 commit index", 128'(csr_wr_idx), 128'h6);
    check("R4 commit value", wide_wr_data, {32'hF3, 32'hF2, 32'hF1, 32'hF0});

    // R5 restart on a different SRAM word
    wr(1'b0, 20'hC0020, 64'h10);
    wr(1'b0, 20'hC002C, 64'h21);
    wr(1'b0, 20'hC0028, 64'h20);
    check("R5 sram strobe", 128'(sram_wr_en), 128'h1);
    check("R5 sram index", 128'(sram_wr_idx), 128'h5);
    check("R5 sram value", 128'(sram_wr_data), 128'h00000021_00000020);

    // R6 R7 R11 descriptor handling in page 3
    wr(1'b0, 20'h06830, 64'hA0);
    wr(1'b0, 20'h06834, 64'hA1);
    wr(1'b0, 20'h06A10, 64'hB0);
    check("R7 discarded write gives no strobe", 128'(strobes()), 128'h0);
    wr(1'b0, 20'h06A1C, 64'hB3);
    check("R6 tx commit strobe", 128'(desc_wr_en), 128'h1);
    check("R6 tx flag", 128'(desc_wr_tx), 128'h1);
    check("R6 page", 128'(page_idx), 128'h3);
    check("R6 tx zero fill", wide_wr_data, {32'hB3, 96'h0});
    wr(1'b0, 20'h0683C, 64'hA3);
    check("R6 rx flag", 128'(desc_wr_tx), 128'h0);
    check("R11 R7 rx value keeps collected dwords", wide_wr_data, {32'hA3, 32'h0, 32'hA1, 32'hA0});

    // R9 invalidation only in page 0
    wr(1'b0, 20'h80070, 64'h1);
    wr(1'b1, 20'h80078, 64'h3_00000002);
    wr(1'b0, 20'h00420, 64'hCC);
    check("R8 forward strobe", 128'(dw_wr_en), 128'h1);
    check("R8 select 0x420", 128'(dw_wr_sel), 128'h1);
    check("R8 data", 128'(dw_wr_data), 128'hCC);
    wr(1'b0, 20'h80074, 64'h9);
    check("R9 page 0 write emptied collector", 128'(csr_wr_en), 128'h0);
    wr(1'b0, 20'h80080, 64'h1);
    wr(1'b1, 20'h80088, 64'h3_00000002);
    wr(1'b0, 20'h02420, 64'hDD);
    check("R9 page 1 forward page", 128'(page_idx), 128'h1);
    wr(1'b0, 20'h80084, 64'h9);
    check("R9 page 1 keeps collector", wide_wr_data, {32'h3, 32'h2, 32'h9, 32'h1});

    // R8 qword to plain register ignored; select 0 for 0x400
    wr(1'b1, 20'h02400, 64'h1234);
    check("R8 qword ignored", 128'(strobes()), 128'h0);
    wr(1'b0, 20'h00400, 64'h5A);
    check("R8 select 0x400", 128'(dw_wr_sel), 128'h0);

    // R1 reset empties collector
    wr(1'b0, 20'h08830, 64'h77);
    do_reset();
    wr(1'b0, 20'h0883C, 64'h88);
    check("R1 collector empty after reset", wide_wr_data, {32'h88, 96'h0});

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule